// File: doc/BRIEF.md
# Synchronous Serial Port Register File

This block is the memory-mapped control and status front end of a synchronous serial port master. A register bus lets software set the word size, enable the port, load words into an 8-entry transmit queue and drain an 8-entry receive queue. Software can also read status flags, program an interrupt mask, clear sticky interrupt causes and read identification bytes. Each word written for transmission is trimmed to the programmed word size. The oldest queued word goes to an external transfer engine through a valid/ready port. Words that the engine receives come back through a second valid/ready port and are trimmed the same way.

A single level interrupt output is raised when any enabled raw cause is active. Two causes are queue fill levels, and software cannot clear them. The other two are sticky events: the engine offering a word while the receive queue is full, and a receive-timeout pulse from the engine. Software clears these by writing ones to the clear register. The block does no serial shifting, no DMA handshake and no slave operation.

Register map (word offsets, 12-bit address): 0x00 format, 0x04 port control, 0x08 data, 0x0C status, 0x10 prescale, 0x14 interrupt enable, 0x18 raw causes, 0x1C enabled causes, 0x20 cause clear, 0x24 DMA control. A read returns data in `reg_rdata` on the clock edge that samples `reg_rd`, so the value is visible from then until the next read.

Top module: `ssp_regfile`

## Requirements
- R1: After reset, status reads 0x03, raw causes read 0x08, enabled causes read 0, `irq_o` is low, `xfer_tx_valid` is low and `xfer_rx_ready` is high.
- R2: Bits [3:0] of the format register (0x00) hold size-1. Every word entering either queue is ANDed with (1 << (size-1 field + 1)) - 1. The format register reads back what was written.
- R3: The status bits are: bit0 transmit queue empty, bit1 transmit queue not full, bit2 receive queue not empty, bit3 receive queue holds 8, bit4 busy (transmit queue holds at least one word).
- R4: Raw cause bit2 is set while the receive queue holds 4 or more words. Raw cause bit3 is set while the transmit queue holds 4 or fewer words.
- R5: `irq_o` is high exactly when (raw causes AND enable register at 0x14) is nonzero. Offset 0x1C reads that AND, and the enable register reads back its low 4 bits.
- R6: A write to 0x20 clears raw cause bit0 and bit1 wherever the written bit is 1. It has no effect on bit2 or bit3.
- R7: Raw cause bit0 is set when `xfer_rx_valid` is high while the receive queue is full, and that word is dropped. Raw cause bit1 is set by a high cycle of `xfer_rx_timeout`.
- R8: Reading data (0x08) with an empty receive queue returns 0 and changes nothing. Writing data to a full transmit queue is discarded.
- R9: Reads of 0xFE0 to 0xFFC return the byte at index (offset-0xFE0)/4 of the list 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Prescale (0x10) keeps only the low 8 bits written. DMA control (0x24) always reads 0. Unmapped offsets read 0 and ignore writes.
- R11: `xfer_tx_valid` is high only when port control bit1 is set, the transmit queue is non-empty and the receive queue is not full. Words leave in write order. `xfer_rx_ready` is high while the receive queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rd | input | 1 | Register read strobe (data read pops the receive queue) |
| reg_rdata | output | 16 | Read data, registered |
| irq_o | output | 1 | Level interrupt |
| xfer_tx_data | output | 16 | Oldest transmit word |
| xfer_tx_valid | output | 1 | Transmit word offered |
| xfer_tx_ready | input | 1 | Engine takes the offered word |
| xfer_rx_data | input | 16 | Received word from engine |
| xfer_rx_valid | input | 1 | Received word present |
| xfer_rx_ready | output | 1 | Receive queue has room |
| xfer_rx_timeout | input | 1 | Receive-timeout event pulse |

## Verification
A wrong queue pointer or count shows at the ports within a few cycles. The next data read or transmit handoff returns a word out of order, and the status and raw-cause bits stop tracking the number of words the bench has pushed and popped. The bench therefore fills each queue past its thresholds and up to full, then drains it while comparing every word. A stuck sticky cause or a wrong size mask appears on the first read of the raw-cause register or on the first word handed out after the bad state arises.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int unsigned REG_AW   = 12;
    localparam int unsigned REG_DW   = 16;
    localparam int unsigned CAUSE_W  = 4;
    localparam int unsigned STAT_W   = 5;
    localparam int unsigned CTL1_W   = 4;
    localparam int unsigned PRESC_W  = 8;

    localparam logic [REG_AW-1:0] OFS_FMT   = 12'h000;
    localparam logic [REG_AW-1:0] OFS_CTL   = 12'h004;
    localparam logic [REG_AW-1:0] OFS_DATA  = 12'h008;
    localparam logic [REG_AW-1:0] OFS_STAT  = 12'h00C;
    localparam logic [REG_AW-1:0] OFS_PRESC = 12'h010;
    localparam logic [REG_AW-1:0] OFS_IEN   = 12'h014;
    localparam logic [REG_AW-1:0] OFS_RAW   = 12'h018;
    localparam logic [REG_AW-1:0] OFS_MSK   = 12'h01C;
    localparam logic [REG_AW-1:0] OFS_CLR   = 12'h020;
    localparam logic [REG_AW-1:0] OFS_DMA   = 12'h024;
    localparam logic [REG_AW-1:0] OFS_IDLO  = 12'hFE0;

    // cause bit positions
    localparam int unsigned CZ_OVR = 0;
    localparam int unsigned CZ_TMO = 1;
    localparam int unsigned CZ_RXL = 2;
    localparam int unsigned CZ_TXL = 3;

    // port control enable bit
    localparam int unsigned CTL_EN = 1;

    typedef struct packed {
        logic [REG_DW-1:0]  fmt;
        logic [CTL1_W-1:0]  ctl;
        logic [PRESC_W-1:0] presc;
        logic [CAUSE_W-1:0] ien;
        logic [1:0]         sticky;
        logic [REG_DW-1:0]  rdata;
    } regs_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h22;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ssp_word_fifo.sv
module ssp_word_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    assign full  = (st_q.cnt == FULL_CNT);
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign head  = st_q.mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);  // R8

    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));  // R8

    AST_EMPTY_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);  // R8

endmodule

// File: rtl/ssp_flags.sv
module ssp_flags
    import ssp_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input  logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input  logic [1:0]                 sticky,
    input  logic [CAUSE_W-1:0]         ien,
    output logic [STAT_W-1:0]          status,
    output logic [CAUSE_W-1:0]         raw,
    output logic [CAUSE_W-1:0]         masked,
    output logic                       irq
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    always_comb begin
        status    = '0;
        status[0] = (tx_cnt == '0);
        status[1] = (tx_cnt != FULL_CNT);
        status[2] = (rx_cnt != '0);
        status[3] = (rx_cnt == FULL_CNT);
        status[4] = (tx_cnt != '0);

        raw          = '0;
        raw[CZ_OVR]  = sticky[0];
        raw[CZ_TMO]  = sticky[1];
        raw[CZ_RXL]  = (rx_cnt >= HALF_CNT);
        raw[CZ_TXL]  = (tx_cnt <= HALF_CNT);

        masked = raw & ien;
        irq    = |masked;
    end

endmodule

// File: rtl/ssp_regfile.sv
module ssp_regfile
    import ssp_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       reg_addr,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    input  logic              reg_rd,
    output logic [15:0]       reg_rdata,
    output logic              irq_o,
    output logic [DATA_W-1:0] xfer_tx_data,
    output logic              xfer_tx_valid,
    input  logic              xfer_tx_ready,
    input  logic [DATA_W-1:0] xfer_rx_data,
    input  logic              xfer_rx_valid,
    output logic              xfer_rx_ready,
    input  logic              xfer_rx_timeout
);
    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

    regs_t st_d, st_q;

    logic [DATA_W-1:0]  word_mask;
    logic               tx_push, tx_pop, rx_push, rx_pop;
    logic [DATA_W-1:0]  tx_head, rx_head;
    logic [CNT_W-1:0]   tx_cnt, rx_cnt;
    logic               tx_full, tx_empty, rx_full, rx_empty;
    logic [STAT_W-1:0]  status;
    logic [CAUSE_W-1:0] raw, masked;
    logic               irq_w;
    logic               is_id;

    // size mask from the low 4 bits of the format register
    always_comb begin
        word_mask = DATA_W'((32'd1 << ({28'd0, st_q.fmt[3:0]} + 32'd1)) - 32'd1);
    end

    assign is_id   = (reg_addr >= OFS_IDLO);
    assign tx_push = reg_wr && (reg_addr == OFS_DATA);
    assign rx_pop  = reg_rd && (reg_addr == OFS_DATA);
    assign xfer_tx_valid = st_q.ctl[CTL_EN] && !tx_empty && !rx_full;
    assign tx_pop  = xfer_tx_valid && xfer_tx_ready;
    assign xfer_rx_ready = !rx_full;
    assign rx_push = xfer_rx_valid && !rx_full;
    assign xfer_tx_data = tx_head;

    ssp_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (reg_wdata[DATA_W-1:0] & word_mask),
        .pop       (tx_pop),
        .head      (tx_head),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    ssp_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (xfer_rx_data & word_mask),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    ssp_flags #(.DEPTH(FIFO_DEPTH)) u_flags (
        .tx_cnt (tx_cnt),
        .rx_cnt (rx_cnt),
        .sticky (st_q.sticky),
        .ien    (st_q.ien),
        .status (status),
        .raw    (raw),
        .masked (masked),
        .irq    (irq_w)
    );

    always_comb begin
        st_d = st_q;

        if (reg_wr) begin
            case (reg_addr)
                OFS_FMT:   st_d.fmt   = reg_wdata;
                OFS_CTL:   st_d.ctl   = reg_wdata[CTL1_W-1:0];
                OFS_PRESC: st_d.presc = reg_wdata[PRESC_W-1:0];
                OFS_IEN:   st_d.ien   = reg_wdata[CAUSE_W-1:0];
                OFS_CLR:   st_d.sticky = st_q.sticky & ~reg_wdata[1:0];
                default:   ;
            endcase
        end

        // sticky events win over a clear in the same cycle
        if (xfer_rx_valid && rx_full) st_d.sticky[0] = 1'b1;
        if (xfer_rx_timeout)          st_d.sticky[1] = 1'b1;

        if (reg_rd) begin
            if (is_id) begin
                st_d.rdata = {8'h00, id_byte(reg_addr[4:2])};
            end else begin
                case (reg_addr)
                    OFS_FMT:   st_d.rdata = st_q.fmt;
                    OFS_CTL:   st_d.rdata = REG_DW'(st_q.ctl);
                    OFS_DATA:  st_d.rdata = rx_empty ? '0 : REG_DW'(rx_head);
                    OFS_STAT:  st_d.rdata = REG_DW'(status);
                    OFS_PRESC: st_d.rdata = REG_DW'(st_q.presc);
                    OFS_IEN:   st_d.rdata = REG_DW'(st_q.ien);
                    OFS_RAW:   st_d.rdata = REG_DW'(raw);
                    OFS_MSK:   st_d.rdata = REG_DW'(masked);
                    default:   st_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign irq_o     = irq_w;

    AST_NO_TX_WHEN_RX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_rx_ready |-> !xfer_tx_valid);  // R11

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctl[CTL_EN] |-> !xfer_tx_valid);  // R11

    AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ien == '0) |-> !irq_o);  // R5

    AST_CLEAR_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CLR && reg_wdata[CZ_OVR] && !(xfer_rx_valid && rx_full))
        |=> !raw[CZ_OVR]);  // R6

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_DATA && rx_empty) |=> (reg_rdata == '0));  // R8

    AST_TX_EMPTY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> raw[CZ_TXL]);  // R4

    AST_ID_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && is_id) |=> (reg_rdata[15:8] == 8'h00));  // R9

endmodule

// File: tb/tb_ssp_regfile.sv
`timescale 1ns/1ps
module tb_ssp_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_rdata;
    logic        irq_o;
    logic [15:0] xfer_tx_data;
    logic        xfer_tx_valid;
    logic        xfer_tx_ready = 1'b0;
    logic [15:0] xfer_rx_data = '0;
    logic        xfer_rx_valid = 1'b0;
    logic        xfer_rx_ready;
    logic        xfer_rx_timeout = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ssp_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_o(irq_o),
        .xfer_tx_data(xfer_tx_data), .xfer_tx_valid(xfer_tx_valid),
        .xfer_tx_ready(xfer_tx_ready), .xfer_rx_data(xfer_rx_data),
        .xfer_rx_valid(xfer_rx_valid), .xfer_rx_ready(xfer_rx_ready),
        .xfer_rx_timeout(xfer_rx_timeout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic take_tx(input string req, input logic [15:0] exp);
        @(negedge clk);
        chk({req, " valid"}, xfer_tx_valid, 1'b1);
        chk({req, " word"}, xfer_tx_data, exp);
        xfer_tx_ready = 1'b1;
        @(negedge clk);
        xfer_tx_ready = 1'b0;
    endtask

    task automatic give_rx(input logic [15:0] w);
        @(negedge clk);
        xfer_rx_data = w; xfer_rx_valid = 1'b1;
        @(negedge clk);
        xfer_rx_valid = 1'b0;
    endtask

    function automatic logic [15:0] size_mask(input int f);
        return 16'((32'd1 << (f + 1)) - 1);
    endfunction

    task automatic t_reset();
        rd_chk("R1 status", 12'h00C, 16'h0003);
        rd_chk("R1 raw", 12'h018, 16'h0008);
        rd_chk("R1 masked", 12'h01C, 16'h0000);
        chk("R1 irq", irq_o, 1'b0);
        chk("R1 tx_valid", xfer_tx_valid, 1'b0);
        chk("R1 rx_ready", xfer_rx_ready, 1'b1);
    endtask

    task automatic t_mask_order();
        wr(12'h000, 16'h0007);
        rd_chk("R2 fmt readback", 12'h000, 16'h0007);
        wr(12'h008, 16'h01A5);
        wr(12'h008, 16'h01FF);
        @(negedge clk);
        chk("R11 disabled no offer", xfer_tx_valid, 1'b0);
        wr(12'h004, 16'h0002);
        take_tx("R2 R11 first", 16'h1A5 & size_mask(7));
        take_tx("R11 second", 16'h1FF & size_mask(7));
        @(negedge clk);
        chk("R11 drained", xfer_tx_valid, 1'b0);
        wr(12'h000, 16'h0003);
        give_rx(16'h0FFF);
        rd_chk("R2 rx masked", 12'h008, 16'h0FFF & size_mask(3));
        rd_chk("R8 empty read", 12'h008, 16'h0000);
        rd_chk("R8 status after empty read", 12'h00C, 16'h0003);
    endtask

    task automatic t_tx_levels();
        logic [15:0] v;
        wr(12'h004, 16'h0000);
        wr(12'h000, 16'h000F);
        for (int i = 0; i < 4; i++) wr(12'h008, 16'h0100 + 16'(i));
        rd(12'h018, v);
        chk("R4 tx level 4 set", v[3], 1'b1);
        rd_chk("R3 status 4 queued", 12'h00C, 16'h0012);
        wr(12'h008, 16'h0104);
        rd(12'h018, v);
        chk("R4 tx level 5 clear", v[3], 1'b0);
        for (int i = 5; i < 8; i++) wr(12'h008, 16'h0100 + 16'(i));
        rd_chk("R3 status tx full", 12'h00C, 16'h0010);
        wr(12'h008, 16'hBEEF);
        wr(12'h004, 16'h0002);
        for (int i = 0; i < 8; i++) take_tx("R8 R11 drain", 16'h0100 + 16'(i));
        @(negedge clk);
        chk("R8 full write dropped", xfer_tx_valid, 1'b0);
        rd_chk("R3 status empty again", 12'h00C, 16'h0003);
    endtask

    task automatic t_rx_levels();
        logic [15:0] v;
        for (int i = 0; i < 3; i++) give_rx(16'h0200 + 16'(i));
        rd(12'h018, v);
        chk("R4 rx level 3 clear", v[2], 1'b0);
        rd_chk("R3 status rx 3", 12'h00C, 16'h0007);
        give_rx(16'h0203);
        rd(12'h018, v);
        chk("R4 rx level 4 set", v[2], 1'b1);
        for (int i = 4; i < 8; i++) give_rx(16'h0200 + 16'(i));
        rd_chk("R3 status rx full", 12'h00C, 16'h000F);
        chk("R11 rx_ready low", xfer_rx_ready, 1'b0);
        wr(12'h008, 16'h0333);
        @(negedge clk);
        chk("R11 stall while rx full", xfer_tx_valid, 1'b0);
        rd(12'h018, v);
        chk("R7 no overrun yet", v[0], 1'b0);
        give_rx(16'hDEAD);
        rd(12'h018, v);
        chk("R7 overrun set", v[0], 1'b1);
        for (int i = 0; i < 8; i++) rd_chk("R7 R8 rx order", 12'h008, 16'h0200 + 16'(i));
        rd_chk("R7 dropped word absent", 12'h008, 16'h0000);
        take_tx("R11 resumes", 16'h0333);
    endtask

    task automatic t_clear();
        @(negedge clk);
        xfer_rx_timeout = 1'b1;
        @(negedge clk);
        xfer_rx_timeout = 1'b0;
        rd_chk("R7 timeout and overrun", 12'h018, 16'h000B);
        wr(12'h020, 16'h0002);
        rd_chk("R6 clear only timeout", 12'h018, 16'h0009);
        wr(12'h020, 16'h000F);
        rd_chk("R6 level cause kept", 12'h018, 16'h0008);
    endtask

    task automatic t_irq();
        wr(12'h014, 16'h0008);
        @(negedge clk);
        chk("R5 irq on", irq_o, 1'b1);
        rd_chk("R5 masked tx", 12'h01C, 16'h0008);
        wr(12'h014, 16'h0004);
        @(negedge clk);
        chk("R5 irq off", irq_o, 1'b0);
        rd_chk("R5 masked none", 12'h01C, 16'h0000);
        rd_chk("R5 enable readback", 12'h014, 16'h0004);
        wr(12'h014, 16'h0000);
    endtask

    task automatic t_id();
        logic [7:0] exp [8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++)
            rd_chk("R9 id byte", 12'hFE0 + 12'(4 * i), {8'h00, exp[i]});
    endtask

    task automatic t_misc();
        wr(12'h010, 16'h1234);
        rd_chk("R10 prescale low byte", 12'h010, 16'h0034);
        wr(12'h024, 16'h0003);
        rd_chk("R10 dma zero", 12'h024, 16'h0000);
        wr(12'h030, 16'hFFFF);
        rd_chk("R10 unmapped zero", 12'h030, 16'h0000);
        rd_chk("R10 format untouched", 12'h000, 16'h000F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_order();
        t_tx_levels();
        t_rx_levels();
        t_clear();
        t_irq();
        t_id();
        t_misc();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule